// File: doc/BRIEF.md
# Count/Compare Timer Interrupt Unit

This unit holds a 32-bit cycle counter and a 32-bit compare register of the kind that sits in a processor's system control coprocessor. The counter advances by one on each cycle where the tick-enable input is high, so it can run at a divided rate. A freeze input stops the counter. When the counter steps onto the compare value, a sticky timer-pending flag is set and one of eight interrupt request lines goes high. A 3-bit routing input picks that line.

Both registers are loaded through single-cycle write strobes that share one data bus, and their contents are always visible on output ports. The interrupt is withdrawn only by a write to the compare register, whatever value is written. A parameter decides whether the pending flag is brought out as a status bit. When the flag is hidden, only the interrupt line carries the event.

Top module: `cmp_timer_unit`

## Requirements
- R1: After reset the counter reads 1, the compare register reads 0, timerPending is 0 and all eight irqLines bits are 0.
- R2: In a cycle where tickEn is 1 and holdCount is 0, the counter increases by exactly one at the next clock edge. In a cycle where tickEn is 0, the counter keeps its value.
- R3: While holdCount is 1 the counter keeps its value even when tickEn is 1, and this includes the time the interrupt is pending.
- R4: A cycle with wrCount at 1 loads wrData into the counter at the next edge. This takes priority over a tick in the same cycle and also takes effect while holdCount is 1.
- R5: A cycle with wrCompare at 1 loads wrData into the compare register at the next edge.
- R6: When a tick moves the counter onto a value equal to the compare register, the pending flag is set at the same edge that makes the counter equal.
- R7: Equality that arises from a write to either register does not set the pending flag.
- R8: Once set, the pending flag stays set while the counter moves past the compare value. Only a compare write clears it, at the next edge, and that clear wins over a match in the same cycle.
- R9: irqLines bit number lineSel equals the pending flag and every other bit is 0. A change of lineSel moves the active line in the same cycle, with no clock edge needed.
- R10: With the parameter HAS_STATUS at 0, timerPending is always 0 and irqLines behaves exactly as in R9.
- R11: The counter wraps from 0xFFFFFFFF to 0x00000000 on a tick, and a compare value of 0 is matched by that wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Counter advance enable for this cycle |
| holdCount | input | 1 | Freezes the counter while high |
| wrCount | input | 1 | Load strobe for the counter |
| wrCompare | input | 1 | Load strobe for the compare register; also clears the interrupt |
| wrData | input | 32 | Write data for both registers |
| lineSel | input | 3 | Index of the interrupt line that carries the timer event |
| countOut | output | 32 | Current counter value |
| compareOut | output | 32 | Current compare value |
| timerPending | output | 1 | Pending status flag (0 when HAS_STATUS is 0) |
| irqLines | output | 8 | Interrupt request lines, at most one high |

## Verification
Counter loads, counter advances, compare loads, setting of the pending flag and its clearing all show one clock edge after the cycle that requested them. The routing of irqLines follows lineSel within that same cycle. For this reason the bench drives inputs shortly after a rising edge and advances its reference model once per rising edge. It then compares every output a few nanoseconds after that edge, when the registered values and the combinational routing have both settled. A second instance with the status flag disabled gets the same stimulus and is compared on each clock.

// File: rtl/ctu_pkg.sv
package ctu_pkg;
  typedef struct packed {
    logic loadCount;
    logic advance;
    logic loadCompare;
    logic setPend;
    logic clrPend;
  } ctuStrobes_t;
endpackage

// File: rtl/ctu_ctrl.sv
module ctu_ctrl
  import ctu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tickEn,
  input  logic        holdCount,
  input  logic        wrCount,
  input  logic        wrCompare,
  input  logic        matchNext,
  output ctuStrobes_t stb
);
  always_comb begin
    stb.loadCount   = wrCount;
    stb.advance     = tickEn && !holdCount && !wrCount;
    stb.loadCompare = wrCompare;
    stb.clrPend     = wrCompare;
    stb.setPend     = tickEn && !holdCount && !wrCount && matchNext && !wrCompare;
  end

  // R8: a clear request and a set request are never issued together
  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stb.clrPend |-> !stb.setPend);
endmodule

// File: rtl/ctu_datapath.sv
module ctu_datapath
  import ctu_pkg::*;
#(
  parameter int          WIDTH       = 32,
  parameter logic [31:0] RESET_COUNT = 32'd1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctuStrobes_t      stb,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] countQ,
  output logic [WIDTH-1:0] compareQ,
  output logic             pendQ,
  output logic             matchNext
);
  logic [WIDTH-1:0] nextCount;

  assign nextCount = countQ + WIDTH'(1);
  assign matchNext = (nextCount == compareQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      countQ   <= WIDTH'(RESET_COUNT);
      compareQ <= '0;
      pendQ    <= 1'b0;
    end else begin
      if (stb.loadCount)        countQ <= wrData;
      else if (stb.advance)     countQ <= nextCount;
      if (stb.loadCompare)      compareQ <= wrData;
      if (stb.clrPend)          pendQ <= 1'b0;
      else if (stb.setPend)     pendQ <= 1'b1;
    end
  end

  assert_load_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stb.loadCount |=> countQ == $past(wrData));
  assert_hold_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.loadCount && !stb.advance) |=> $stable(countQ));
  assert_clear_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stb.clrPend |=> !pendQ);
  assert_sticky_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pendQ && !stb.clrPend) |=> pendQ);
  assert_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.advance && !stb.loadCount && countQ == '1) |=> countQ == '0);
endmodule

// File: rtl/ctu_route.sv
module ctu_route #(
  parameter int NUM_LINES = 8,
  localparam int SEL_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pend,
  input  logic [SEL_W-1:0]     lineSel,
  output logic [NUM_LINES-1:0] irqLines
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign irqLines[i] = pend && (lineSel == SEL_W'(i));
  end

  assert_single_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irqLines));
  assert_line_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(irqLines) == 1) == pend);
endmodule

// File: rtl/cmp_timer_unit.sv
module cmp_timer_unit
  import ctu_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int NUM_LINES  = 8,
  parameter bit HAS_STATUS = 1'b1,
  localparam int SEL_W = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tickEn,
  input  logic                 holdCount,
  input  logic                 wrCount,
  input  logic                 wrCompare,
  input  logic [WIDTH-1:0]     wrData,
  input  logic [SEL_W-1:0]     lineSel,
  output logic [WIDTH-1:0]     countOut,
  output logic [WIDTH-1:0]     compareOut,
  output logic                 timerPending,
  output logic [NUM_LINES-1:0] irqLines
);
  ctuStrobes_t stb;
  logic        matchNext;
  logic        pendQ;

  ctu_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .holdCount(holdCount),
    .wrCount(wrCount), .wrCompare(wrCompare), .matchNext(matchNext), .stb(stb)
  );

  ctu_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .wrData(wrData),
    .countQ(countOut), .compareQ(compareOut), .pendQ(pendQ), .matchNext(matchNext)
  );

  ctu_route #(.NUM_LINES(NUM_LINES)) u_route (
    .clk(clk), .rst_n(rst_n), .pend(pendQ), .lineSel(lineSel), .irqLines(irqLines)
  );

  if (HAS_STATUS) begin : g_status
    assign timerPending = pendQ;
  end else begin : g_nostatus
    assign timerPending = 1'b0;
  end

  // R6/R7: pending only rises after a tick that lands on the compare value
  assert_match_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pendQ && !wrCompare && (wrCount || !tickEn || holdCount)) |=> !pendQ);
  assert_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (holdCount && !wrCount) |=> countOut == $past(countOut));
endmodule

// File: tb/cmp_timer_unit_test.sv
module cmp_timer_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tickEn = 1'b0, holdCount = 1'b0, wrCount = 1'b0, wrCompare = 1'b0;
  logic [31:0] wrData = '0;
  logic [2:0]  lineSel = '0;
  logic [31:0] countOut, compareOut, countOut2, compareOut2;
  logic        timerPending, timerPending2;
  logic [7:0]  irqLines, irqLines2;

  int    nChecks = 0, nFails = 0;
  string curReq = "R1";
  logic [31:0] mCnt = 32'd1, mCmp = 32'd0;
  bit          mPend = 1'b0;

  always #10 clk = ~clk;

  cmp_timer_unit uut (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .holdCount(holdCount),
    .wrCount(wrCount), .wrCompare(wrCompare), .wrData(wrData), .lineSel(lineSel),
    .countOut(countOut), .compareOut(compareOut), .timerPending(timerPending),
    .irqLines(irqLines));

  cmp_timer_unit #(.HAS_STATUS(1'b0)) uut2 (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .holdCount(holdCount),
    .wrCount(wrCount), .wrCompare(wrCompare), .wrData(wrData), .lineSel(lineSel),
    .countOut(countOut2), .compareOut(compareOut2), .timerPending(timerPending2),
    .irqLines(irqLines2));

  task automatic chk(input logic [31:0] got, input logic [31:0] exp,
                     input string req, input string what);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic checkAll();
    logic [7:0] expLines;
    expLines = mPend ? (8'd1 << lineSel) : 8'd0;
    chk(countOut, mCnt, curReq, "count");
    chk(compareOut, mCmp, curReq, "compare");
    chk({31'd0, timerPending}, {31'd0, mPend}, curReq, "pending");
    chk({24'd0, irqLines}, {24'd0, expLines}, curReq, "irqLines");
    chk({31'd0, timerPending2}, 32'd0, "R10", "hidden pending");
    chk({24'd0, irqLines2}, {24'd0, expLines}, "R10", "irqLines no-status");
  endtask

  // one clock: advance model from the inputs held during the cycle, then compare
  task automatic cyc();
    logic [31:0] oldCnt;
    bit adv;
    @(posedge clk);
    oldCnt = mCnt;
    adv = tickEn && !holdCount && !wrCount;
    if (!rst_n) begin
      mCnt = 32'd1; mCmp = 32'd0; mPend = 1'b0;
    end else begin
      if (wrCount) mCnt = wrData;
      else if (adv) mCnt = oldCnt + 32'd1;
      if (wrCompare) mPend = 1'b0;
      else if (adv && (oldCnt + 32'd1) == mCmp) mPend = 1'b1;
      if (wrCompare) mCmp = wrData;
    end
    #2;
    checkAll();
    tickEn = 1'b0; wrCount = 1'b0; wrCompare = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tickEn = 1'b1;
      cyc();
    end
  endtask

  task automatic writeCmp(input logic [31:0] v);
    wrCompare = 1'b1; wrData = v; cyc();
  endtask

  task automatic writeCnt(input logic [31:0] v, input bit withTick);
    wrCount = 1'b1; wrData = v; tickEn = withTick; cyc();
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    curReq = "R1";
    cyc(); cyc();
    rst_n = 1'b1;
    #5 checkAll();   // R1 reset values

    curReq = "R2";
    ticks(3);
    cyc(); cyc();    // idle cycles, no tick: hold
    for (int i = 0; i < 4; i++) begin
      tickEn = 1'b1; cyc(); cyc(); cyc();
    end

    curReq = "R5";
    writeCmp(32'd20);

    curReq = "R6";
    while (mCnt != 32'd20) ticks(1);
    chk({31'd0, timerPending}, 32'd1, "R6", "pending at match");

    curReq = "R8";
    ticks(4);
    chk({31'd0, timerPending}, 32'd1, "R8", "pending past match");

    curReq = "R9";
    for (int s = 0; s < 8; s++) begin
      lineSel = 3'(s); #1;
      chk({24'd0, irqLines}, {24'd0, 8'd1 << s}, "R9", "line moves on select");
      cyc();
    end

    curReq = "R3";
    holdCount = 1'b1;
    ticks(5);
    chk(countOut, 32'd24, "R3", "frozen count while pending");

    curReq = "R4";
    writeCnt(32'd100, 1'b1);
    chk(countOut, 32'd100, "R4", "load while frozen");
    holdCount = 1'b0;
    writeCnt(32'd200, 1'b1);
    chk(countOut, 32'd200, "R4", "load beats tick");

    curReq = "R8";
    writeCmp(32'd500);
    chk({31'd0, timerPending}, 32'd0, "R8", "compare write clears");

    curReq = "R7";
    writeCnt(32'd500, 1'b0);
    ticks(1);
    chk({31'd0, timerPending}, 32'd0, "R7", "count write equal no set");
    writeCmp(32'd501);
    ticks(2);
    chk({31'd0, timerPending}, 32'd0, "R7", "compare write equal no set");

    curReq = "R8";
    writeCmp(32'd510);
    writeCnt(32'd508, 1'b0);
    tickEn = 1'b1; cyc();          // count 509
    tickEn = 1'b1; wrCompare = 1'b1; wrData = 32'd510; cyc();  // match + write
    chk({31'd0, timerPending}, 32'd0, "R8", "clear wins over match");

    curReq = "R11";
    lineSel = 3'd5;
    writeCmp(32'd0);
    writeCnt(32'hFFFF_FFFD, 1'b0);
    ticks(2);
    chk({31'd0, timerPending}, 32'd0, "R11", "no pend before wrap");
    ticks(1);
    chk(countOut, 32'd0, "R11", "wrapped to zero");
    chk({31'd0, timerPending}, 32'd1, "R11", "match at wrap");
    ticks(3);
    writeCmp(32'd7);

    curReq = "R2";
    ticks(10);
    cyc();
    finishRun();
  end
endmodule